// File: doc/BRIEF.md
# OTP Bank Read Controller

This block fetches one bank of a one-time-programmable array into four word-wide data registers. Software sets up the fetch through a small register bus. It writes the bit address of the bank into the address register. It then writes the read command bit in the control register and polls a done flag in the status register until the flag is set.

The controller then walks the bank one word at a time. It holds each array access for a programmable number of clock cycles before it takes the word. When the last word arrives, all four data registers update together and the done flag sets. The done flag stays set until software clears it by writing a 0 to it.

The array port is behavioural: while the enable is high, the array returns one 32-bit word for the word index it is given. The control register also holds mode bits for alternate keys, secure loading, CRC and trimming. The block stores these bits and reads them back, but does not act on them.

Top module: `otp_bank_reader`

## Requirements
- R1: After reset, every register returns 0: control at 0x48, status at 0x4C, address at 0x50, and data at 0x20, 0x24, 0x28 and 0x2C.
- R2: Control bits 15:8 (read period) and bits 5, 4, 3, 1 and 0 (mode bits) are plain storage and read back as written. Control bit 2 and all other bits read as 0.
- R3: Writing control with bit 2 at 1 while idle starts a fetch. The fetched bank index is the value held at 0x50 shifted right by 7, that is, the bit address divided by 128. The address register keeps all 32 bits and reads them back.
- R4: A fetch makes 4 word accesses, each lasting max(P,1) cycles, where P is control bits 15:8 captured at the start. The done flag reads 1 first after clock edge 4·max(P,1), counted from the edge that accepted the command, and reads 0 one edge earlier.
- R5: For a bank index below 8, otp_en is high for exactly 4·max(P,1) cycles per fetch. During word w's access, otp_addr equals bank·4 + w.
- R6: Data register at 0x20 + 4·w holds word w of the last completed fetch, with byte n in bits 8n+7:8n. The data registers change only when a fetch completes. They do not change during a fetch or when the address register is rewritten.
- R7: For a bank index of 8 or more, otp_en stays low, all four data words complete as 0, and the done flag still sets with the same timing as R4.
- R8: Status bit 4 (done) stays set until a status write with bit 4 at 0 clears it. A status write with bit 4 at 1 leaves it unchanged. Status bit 2 (secure-load done) reads 0, because this block never sets it.
- R9: A start command written while a fetch is running is ignored. The running fetch keeps its timing, and no second fetch follows it.
- R10: Any offset other than the eight listed in R1 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register bus select; with bus_we set, a write takes effect at the clock edge |
| bus_we | input | 1 | Write enable |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, a combinational function of bus_addr |
| otp_en | output | 1 | Array access enable |
| otp_addr | output | 5 | Word index into the array: bank·4 + word |
| otp_rdata | input | 32 | Word returned by the array while otp_en is high |

## Verification
If the access counter or the word counter slips by one, the done flag moves by at least one edge. The bench samples the flag on both sides of the predicted edge, so a slip fails in the first fetch. A wrong captured bank or word index shows up on otp_addr during the access cycle itself, and in the data registers at the completion edge. A stale busy or start state shows up as extra array-enable cycles, or as a done flag that sets again after software has cleared it, within a few tens of cycles of the ignored command.

// File: rtl/otp_bank_reader.sv
module otp_bank_reader #(
  parameter int NUM_BANKS = 8,
  parameter int WORDS     = 4,
  parameter int DW        = 32,
  parameter int AW        = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  bus_sel,
  input  logic                                  bus_we,
  input  logic [AW-1:0]                         bus_addr,
  input  logic [DW-1:0]                         bus_wdata,
  output logic [DW-1:0]                         bus_rdata,
  output logic                                  otp_en,
  output logic [$clog2(NUM_BANKS*WORDS)-1:0]    otp_addr,
  input  logic [DW-1:0]                         otp_rdata
);
  localparam int WIW = $clog2(WORDS);
  localparam int BIW = $clog2(NUM_BANKS);
  localparam int BSH = $clog2(WORDS*DW);
  localparam logic [AW-1:0] CTRL_OFF = AW'(8'h48);
  localparam logic [AW-1:0] STAT_OFF = AW'(8'h4C);
  localparam logic [AW-1:0] ADDR_OFF = AW'(8'h50);
  localparam logic [AW-1:0] DATA_OFF = AW'(8'h20);
  localparam logic [DW-1:0] CTRL_MASK = DW'(32'h0000_FF3B);

  logic [DW-1:0]  ctrl_q, addr_q;
  logic           done_q, busy, oob_q;
  logic [WIW-1:0] word_q;
  logic [7:0]     cnt_q, per_q;
  logic [BIW-1:0] bank_q;
  logic [DW-1:0]  shadow_q [WORDS];
  logic [DW-1:0]  data_q   [WORDS];

  wire wr     = bus_sel && bus_we;
  wire start  = wr && bus_addr == CTRL_OFF && bus_wdata[2] && !busy;
  wire oob_in = (addr_q >> BSH) >= DW'(NUM_BANKS);
  wire tick   = busy && cnt_q == per_q - 8'd1;
  wire finish = tick && word_q == WIW'(WORDS-1);
  wire [DW-1:0] word_val = oob_q ? '0 : otp_rdata;

  assign otp_en   = busy && !oob_q;
  assign otp_addr = {bank_q, word_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
      busy   <= 1'b0;
      oob_q  <= 1'b0;
      word_q <= '0;
      cnt_q  <= '0;
      per_q  <= 8'd1;
      bank_q <= '0;
    end else begin
      if (wr && bus_addr == CTRL_OFF) ctrl_q <= bus_wdata & CTRL_MASK;
      if (wr && bus_addr == ADDR_OFF) addr_q <= bus_wdata;
      if (finish) done_q <= 1'b1;
      else if (wr && bus_addr == STAT_OFF && !bus_wdata[4]) done_q <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        word_q <= '0;
        cnt_q  <= '0;
        per_q  <= (bus_wdata[15:8] == 8'd0) ? 8'd1 : bus_wdata[15:8];
        bank_q <= addr_q[BSH +: BIW];
        oob_q  <= oob_in;
      end else if (busy) begin
        if (tick) begin
          cnt_q  <= '0;
          word_q <= word_q + 1'b1;
          if (finish) busy <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 8'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) begin
        shadow_q[w] <= '0;
        data_q[w]   <= '0;
      end
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        if (tick && word_q == WIW'(w)) shadow_q[w] <= word_val;
        if (finish) data_q[w] <= (w == WORDS-1) ? word_val : shadow_q[w];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_OFF) bus_rdata = ctrl_q;
    if (bus_addr == STAT_OFF) bus_rdata = DW'({done_q, 4'b0000});
    if (bus_addr == ADDR_OFF) bus_rdata = addr_q;
    for (int w = 0; w < WORDS; w++)
      if (bus_addr == DATA_OFF + AW'(4*w)) bus_rdata = data_q[w];
  end
endmodule

module otp_bank_reader_chk #(
  parameter int WORDS = 4,
  parameter int DW    = 32,
  parameter int AW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          busy,
  input logic          done_q,
  input logic          oob_q,
  input logic          otp_en,
  input logic          finish,
  input logic [DW-1:0] data_q [WORDS]
);
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !(bus_sel && bus_we && bus_addr == AW'(8'h4C) && !bus_wdata[4]) |=> done_q);

  a_r5_en_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    otp_en |-> busy);

  a_r7_oob_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    busy && oob_q |-> !otp_en);

  a_r3_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_sel && bus_we && bus_addr == AW'(8'h48) && bus_wdata[2]));

  a_r4_done_at_finish: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> done_q && !busy);

  for (genvar w = 0; w < WORDS; w++) begin : g_hold
    a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !finish |=> $stable(data_q[w]));
  end
endmodule

bind otp_bank_reader otp_bank_reader_chk #(.WORDS(WORDS), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy), .done_q(done_q),
  .oob_q(oob_q), .otp_en(otp_en), .finish(finish), .data_q(data_q));

// File: tb/test_otp_bank_reader.sv
module test_otp_bank_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        otp_en;
  logic [4:0]  otp_addr;
  logic [31:0] otp_rdata;

  int checks = 0, fails = 0;
  int en_cnt = 0, addr_bad = 0, exp_bank = 0, exp_p = 1;
  bit finished = 0;

  always #2 clk = ~clk;

  function automatic logic [31:0] wf(int a);
    return (32'h9E3779B9 * 32'(a + 1)) ^ 32'(a << 3);
  endfunction

  assign otp_rdata = otp_en ? wf(int'(otp_addr)) : 32'hDEAD_BEEF;

  otp_bank_reader i_otp_bank_reader (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .otp_en(otp_en), .otp_addr(otp_addr), .otp_rdata(otp_rdata));

  always @(negedge clk) if (otp_en) begin
    if (int'(otp_addr) != exp_bank*4 + en_cnt/exp_p) addr_bad++;
    en_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    rd(a, d);
    chk(d === exp, req, d, exp);
  endtask

  task automatic do_read(input int b, input int p);
    int pe = (p == 0) ? 1 : p;
    bit oob = (b >= 8);
    wr(8'h50, 32'(b * 128));
    en_cnt = 0; addr_bad = 0; exp_bank = b; exp_p = pe;
    wr(8'h48, 32'((p << 8) | 4));
    repeat (4*pe - 1) @(posedge clk);
    rd_chk(8'h4C, 32'h0, "R4 done early");
    @(posedge clk);
    rd_chk(8'h4C, 32'h10, oob ? "R7 done set out of range" : "R4 done on time");
    for (int w = 0; w < 4; w++)
      rd_chk(8'(8'h20 + 4*w), oob ? 32'h0 : wf(b*4 + w), oob ? "R7 zero word" : "R6 data word");
    chk(en_cnt == (oob ? 0 : 4*pe), oob ? "R7 no access" : "R5 access cycles", 32'(en_cnt), 32'(oob ? 0 : 4*pe));
    chk(addr_bad == 0, "R5 word index", 32'(addr_bad), 32'h0);
    wr(8'h4C, 32'h0);
    rd_chk(8'h4C, 32'h0, "R8 clear by 0");
  endtask

  initial begin
    logic [31:0] d, b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    rd_chk(8'h48, 32'h0, "R1 ctrl");
    rd_chk(8'h4C, 32'h0, "R1 status");
    rd_chk(8'h50, 32'h0, "R1 address");
    for (int w = 0; w < 4; w++) rd_chk(8'(8'h20 + 4*w), 32'h0, "R1 data");

    wr(8'h48, 32'hFFFF_FFFB);
    rd_chk(8'h48, 32'h0000_FF3B, "R2 ctrl storage");
    wr(8'h48, 32'h0000_0000);
    rd_chk(8'h48, 32'h0, "R2 ctrl zero");
    rd_chk(8'h4C, 32'h0, "R9 no start from storage write");
    wr(8'h50, 32'h1234_5680);
    rd_chk(8'h50, 32'h1234_5680, "R3 address storage");

    foreach (rd_chk_list[i]) ;
    rd_chk(8'h00, 32'h0, "R10 offset 00");
    rd_chk(8'h44, 32'h0, "R10 offset 44");
    rd_chk(8'h54, 32'h0, "R10 offset 54");
    rd_chk(8'h30, 32'h0, "R10 offset 30");
    rd_chk(8'h22, 32'h0, "R10 offset 22");

    wr(8'h4C, 32'hFFFF_FFFF);
    rd_chk(8'h4C, 32'h0, "R8 write 1 does not set");

    for (int b = 0; b < 10; b++)
      for (int k = 0; k < 5; k++)
        do_read(b, (k == 4) ? 7 : k);
    do_read(7, 30);

    rd(8'h20, b0);
    wr(8'h50, 32'(3 * 128));
    repeat (10) @(posedge clk);
    rd_chk(8'h20, b0, "R6 hold after address write");
    wr(8'h4C, 32'h0);

    en_cnt = 0; addr_bad = 0; exp_bank = 3; exp_p = 3;
    wr(8'h48, 32'h0000_0304);
    rd_chk(8'h20, b0, "R6 hold during fetch");
    wr(8'h48, 32'h0000_0104);
    repeat (9) @(posedge clk);
    rd_chk(8'h4C, 32'h0, "R9 timing unchanged early");
    @(posedge clk);
    rd_chk(8'h4C, 32'h10, "R9 timing unchanged done");
    rd_chk(8'h2C, wf(15), "R9 data of first fetch");
    wr(8'h4C, 32'h10);
    rd_chk(8'h4C, 32'h10, "R8 write 1 keeps done");
    wr(8'h4C, 32'hFFFF_FFEF);
    repeat (20) @(posedge clk);
    rd_chk(8'h4C, 32'h0, "R9 no second fetch");
    chk(en_cnt == 12, "R9 access count", 32'(en_cnt), 32'd12);
    chk(addr_bad == 0, "R5 word index late", 32'(addr_bad), 32'h0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  int rd_chk_list [1];

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule